// File: doc/BRIEF.md
# Standby Wake Settling Timer

This block is an 8-bit up-counter that acts as a watchdog during normal operation and as an oscillator-settling timer around clock stops. When software requests standby, the block drops its clock-enable output and the counter holds. A non-maskable-interrupt edge or an interrupt event starts the count. When the count wraps past its top value, the block raises the clock enable again, leaves the overflow flag clear, and keeps counting from zero. If the standby bit is still set when the count reaches the halfway value 0x80, the block drops the clock enable a second time. From that state only a reset brings it back. Clearing the standby bit first stops the count and leaves the clock running.

A write to the frequency control register works in a similar way. The clock stops, the counter runs, and on wrap the clock returns with the flag clear. The counter then halts at a stop value set by the clock-ratio input. A prescaler divides the input clock by one of eight ratios. Software preloads the counter so that the time to wrap is longer than the oscillator settling time.

In normal running with the timer enable set, a wrap sets the overflow flag and issues a one-cycle pulse. The pulse goes on the reset output or on the interval-interrupt output, as chosen by a mode bit.

Top module: `standby_settle_timer`

## Requirements
- R1: After reset the counter reads 0x00, the overflow flag and timer enable are 0, the clock enable is 1 and neither pulse output is high.
- R2: With reg_sel=0 a write sets the control register: bit 7 timer enable, bit 6 mode (1 = reset pulse, 0 = interval-interrupt pulse), bit 2:0 clock select. Bit 5 clears the overflow flag when written 0 and leaves it unchanged when written 1. With reg_sel=1 a write loads the counter, and the new value is visible on count_val in the next cycle.
- R3: Clock-select codes 0..7 give divide ratios 1, 4, 16, 32, 64, 256, 1024 and 4096. The prescaler restarts on every register write and on every count start. The counter advances once every N cycles after that restart.
- R4: In normal running with the timer enable at 1, a wrap from 0xFF to 0x00 sets the flag. It also drives tmr_irq (mode 0) or tmr_rst (mode 1) high for the one cycle after the wrap edge. With the timer enable at 0 the counter holds and neither pulse output rises.
- R5: A standby request drops clk_en in the next cycle, and the counter holds while waiting. An nmi_edge or irq_evt pulse starts the count.
- R6: A wrap during a standby wake-up raises clk_en in the same cycle the counter reads 0x00, and the flag stays 0. Counting then continues from 0x00.
- R7: After a standby wake-up with stby_bit=1, the counter reaching 0x80 drops clk_en in the next cycle. Wake events and frequency writes then have no effect, and only reset restores clk_en.
- R8: Clearing stby_bit while counting after a standby wake-up stops the counter at its current value, and clk_en stays 1.
- R9: A frq_wr pulse drops clk_en in the next cycle and starts the count. The wrap raises clk_en with the flag left at 0.
- R10: After a frequency-change wrap the counter halts at 0x00 when ratio_unity=1 and at 0x01 when ratio_unity=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control register, 1 selects counter |
| reg_wdata | input | CNT_W | Register write data |
| stby_req | input | 1 | Standby request, one-cycle pulse |
| stby_bit | input | 1 | Standby bit level from the power controller |
| nmi_edge | input | 1 | Detected non-maskable-interrupt edge |
| irq_evt | input | 1 | Detected interrupt event |
| frq_wr | input | 1 | Frequency control register write strobe |
| ratio_unity | input | 1 | 1 when the new clock ratio is 1:1 |
| clk_en | output | 1 | Processor clock enable |
| count_val | output | CNT_W | Current counter value |
| ovf_flag | output | 1 | Overflow flag |
| tmr_rst | output | 1 | One-cycle watchdog reset pulse |
| tmr_irq | output | 1 | One-cycle interval interrupt pulse |

## Verification
Register writes and clk_en changes after a standby request or a frequency write are due one cycle after the driving edge. A wrap is due (256 - preload) × N cycles after the restarting edge, where N is the divide ratio. A pulse output appears in the cycle right after the wrap edge. The bench drives inputs on falling edges and counts every rising edge from the stimulus. It checks the outputs one cycle before and exactly at each due edge. The random trials compute these counts with bench functions and sample clk_en and count_val on both sides of the wrap.

// File: rtl/wst_pkg.sv
package wst_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_WAKE,
    ST_POST,
    ST_FREQ,
    ST_FPOST,
    ST_LOCK
  } wst_state_e;

  typedef struct packed {
    logic       ten;
    logic       mode_rst;
    logic       flag;
    logic [2:0] cks;
  } wst_ctrl_t;

  localparam int CTL_TEN  = 7;
  localparam int CTL_MODE = 6;
  localparam int CTL_FLAG = 5;

  function automatic int div_shift(input logic [2:0] cks);
    case (cks)
      3'd0:    return 0;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 8;
      3'd6:    return 10;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/wst_prescaler.sv
module wst_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic [2:0] cks_i,
  output logic       tick_o
);
  import wst_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    int sh;
    sh = div_shift(cks_i);
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < sh) ? 1'b1 : 1'b0;
    end
  end

  assign tick_o = ((pre_q & mask) == mask);

  always_comb begin
    if (clr_i) pre_d = '0;
    else       pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3: right after a restart, no tick unless divide-by-one is selected
  p_prescale_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i ##1 (cks_i != 3'd0) |-> !tick_o);

endmodule

// File: rtl/wst_counter.sv
module wst_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign wrap_o = inc_i && !load_i && (&cnt_q);
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (inc_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: each counting step adds exactly one
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i) |=> (cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1))));

  // R4: without a step or load the value holds
  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !load_i) |=> $stable(cnt_o));

endmodule

// File: rtl/wst_regs.sv
module wst_regs (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ctrl_i,
  input  logic [7:0]          wdata_i,
  input  logic                set_flag_i,
  output wst_pkg::wst_ctrl_t  ctrl_o
);
  import wst_pkg::*;

  wst_ctrl_t ctrl_q;
  wst_ctrl_t ctrl_d;
  logic      unused_rsvd;

  assign unused_rsvd = ^wdata_i[4:3];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl_i) begin
      ctrl_d.ten      = wdata_i[CTL_TEN];
      ctrl_d.mode_rst = wdata_i[CTL_MODE];
      ctrl_d.cks      = wdata_i[2:0];
      ctrl_d.flag     = ctrl_q.flag & wdata_i[CTL_FLAG];
    end
    if (set_flag_i) ctrl_d.flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R2: flag only moves on a write or a set
  p_flag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl_i && !set_flag_i) |=> $stable(ctrl_q.flag));

  // R2: writing 1 to the flag bit never sets it
  p_flag_no_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_i && !set_flag_i && !ctrl_q.flag) |=> !ctrl_q.flag);

endmodule

// File: rtl/wst_fsm.sv
module wst_fsm #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ten_i,
  input  logic             mode_rst_i,
  input  logic             stby_req_i,
  input  logic             stby_bit_i,
  input  logic             wake_nmi_i,
  input  logic             wake_irq_i,
  input  logic             frq_wr_i,
  input  logic             ratio_unity_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  input  logic             tick_i,
  output logic             inc_o,
  output logic             pre_clr_o,
  output logic             set_flag_o,
  output logic             clk_en_o,
  output logic             rst_pulse_o,
  output logic             irq_pulse_o
);
  import wst_pkg::*;

  localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};

  wst_state_e       state_q;
  wst_state_e       state_d;
  logic             count_en;
  logic             wake;
  logic [CNT_W-1:0] stop_val;
  logic             rst_pulse_q;
  logic             irq_pulse_q;
  logic             rst_pulse_d;
  logic             irq_pulse_d;

  assign wake     = wake_nmi_i || wake_irq_i;
  assign stop_val = ratio_unity_i ? '0 : CNT_W'(1);

  always_comb begin
    case (state_q)
      ST_RUN:   count_en = ten_i;
      ST_WAKE:  count_en = 1'b1;
      ST_FREQ:  count_en = 1'b1;
      ST_POST:  count_en = stby_bit_i && (cnt_i != HALF);
      ST_FPOST: count_en = (cnt_i != stop_val);
      default:  count_en = 1'b0;
    endcase
  end

  assign inc_o = tick_i && count_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (stby_req_i)    state_d = ST_IDLE;
        else if (frq_wr_i) state_d = ST_FREQ;
      end
      ST_IDLE:  if (wake) state_d = ST_WAKE;
      ST_WAKE:  if (wrap_i) state_d = ST_POST;
      ST_POST: begin
        if (!stby_bit_i)        state_d = ST_RUN;
        else if (cnt_i == HALF) state_d = ST_LOCK;
      end
      ST_FREQ:  if (wrap_i) state_d = ST_FPOST;
      ST_FPOST: if (cnt_i == stop_val) state_d = ST_RUN;
      ST_LOCK:  state_d = ST_LOCK;
      default:  state_d = ST_RUN;
    endcase
  end

  assign pre_clr_o  = ((state_q == ST_RUN) && frq_wr_i && !stby_req_i) ||
                      ((state_q == ST_IDLE) && wake);
  assign set_flag_o = (state_q == ST_RUN) && wrap_i;

  always_comb begin
    rst_pulse_d = set_flag_o && mode_rst_i;
    irq_pulse_d = set_flag_o && !mode_rst_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      rst_pulse_q <= 1'b0;
      irq_pulse_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rst_pulse_q <= rst_pulse_d;
      irq_pulse_q <= irq_pulse_d;
    end
  end

  assign clk_en_o    = (state_q == ST_RUN) || (state_q == ST_POST) ||
                       (state_q == ST_FPOST);
  assign rst_pulse_o = rst_pulse_q;
  assign irq_pulse_o = irq_pulse_q;

  // R4: timer disabled means no pulse in the following cycle
  p_ten_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ten_i |=> !(rst_pulse_o || irq_pulse_o));

  // R4: the two pulses never coincide
  p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_pulse_o && irq_pulse_o));

  // R5: a standby request gates the clock next cycle
  p_stby_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && stby_req_i) |=> !clk_en_o);

  // R6: leaving the wake count lands on zero
  p_wake_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE) |=> ((state_q != ST_POST) || (cnt_i == '0)));

  // R7: the locked state never releases the clock
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK) |=> ((state_q == ST_LOCK) && !clk_en_o));

  // R8: standby bit cleared after wake returns to normal running
  p_post_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_POST) && !stby_bit_i) |=> (state_q == ST_RUN));

  // R9: a frequency write gates the clock next cycle
  p_freq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && frq_wr_i && !stby_req_i) |=> !clk_en_o);

  // R10: reaching the stop value ends the post-change count
  p_fstop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FPOST) && (cnt_i == stop_val)) |=> (state_q == ST_RUN));

endmodule

// File: rtl/standby_settle_timer.sv
module standby_settle_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             stby_req,
  input  logic             stby_bit,
  input  logic             nmi_edge,
  input  logic             irq_evt,
  input  logic             frq_wr,
  input  logic             ratio_unity,
  output logic             clk_en,
  output logic [CNT_W-1:0] count_val,
  output logic             ovf_flag,
  output logic             tmr_rst,
  output logic             tmr_irq
);
  import wst_pkg::*;

  logic      rst_meta_q;
  logic      rst_sync_n;
  wst_ctrl_t ctrl;
  logic      tick;
  logic      inc;
  logic      wrap;
  logic      fsm_pre_clr;
  logic      pre_clr;
  logic      set_flag;
  logic      wr_ctrl;
  logic      wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign wr_ctrl = reg_wr && !reg_sel;
  assign wr_cnt  = reg_wr && reg_sel;
  assign pre_clr = fsm_pre_clr || reg_wr;

  wst_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_ctrl_i  (wr_ctrl),
    .wdata_i    (reg_wdata[7:0]),
    .set_flag_i (set_flag),
    .ctrl_o     (ctrl)
  );

  wst_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (pre_clr),
    .cks_i  (ctrl.cks),
    .tick_o (tick)
  );

  wst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (wr_cnt),
    .load_val_i (reg_wdata),
    .inc_i      (inc),
    .cnt_o      (count_val),
    .wrap_o     (wrap)
  );

  wst_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .ten_i         (ctrl.ten),
    .mode_rst_i    (ctrl.mode_rst),
    .stby_req_i    (stby_req),
    .stby_bit_i    (stby_bit),
    .wake_nmi_i    (nmi_edge),
    .wake_irq_i    (irq_evt),
    .frq_wr_i      (frq_wr),
    .ratio_unity_i (ratio_unity),
    .cnt_i         (count_val),
    .wrap_i        (wrap),
    .tick_i        (tick),
    .inc_o         (inc),
    .pre_clr_o     (fsm_pre_clr),
    .set_flag_o    (set_flag),
    .clk_en_o      (clk_en),
    .rst_pulse_o   (tmr_rst),
    .irq_pulse_o   (tmr_irq)
  );

  assign ovf_flag = ctrl.flag;

  // R1: leaving reset presents the reset state
  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (clk_en && (count_val == '0) && !ovf_flag &&
                           !tmr_rst && !tmr_irq));

endmodule

// File: tb/standby_settle_timer_tb.sv
module standby_settle_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_sel;
  logic [7:0] reg_wdata;
  logic       stby_req, stby_bit, nmi_edge, irq_evt, frq_wr, ratio_unity;
  logic       clk_en, ovf_flag, tmr_rst, tmr_irq;
  logic [7:0] count_val;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  standby_settle_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .stby_req(stby_req), .stby_bit(stby_bit),
    .nmi_edge(nmi_edge), .irq_evt(irq_evt), .frq_wr(frq_wr),
    .ratio_unity(ratio_unity), .clk_en(clk_en), .count_val(count_val),
    .ovf_flag(ovf_flag), .tmr_rst(tmr_rst), .tmr_irq(tmr_irq)
  );

  function automatic int div_of(input int cks);
    case (cks)
      0: return 1;
      1: return 4;
      2: return 16;
      3: return 32;
      4: return 64;
      5: return 256;
      6: return 1024;
      default: return 4096;
    endcase
  endfunction

  function automatic int wrap_cycles(input int preload, input int cks);
    return (256 - preload) * div_of(cks);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pulses;
    void'($urandom(32'd7019));
    reg_wr = 0; reg_sel = 0; reg_wdata = 0;
    stby_req = 0; stby_bit = 0; nmi_edge = 0; irq_evt = 0; frq_wr = 0; ratio_unity = 1;
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 clk_en", clk_en, 1);
    chk("R1 count", count_val, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 pulses", {tmr_rst, tmr_irq}, 0);

    // R2 counter load visible next cycle
    wr_reg(1, 8'h5A);
    chk("R2 counter load", count_val, 8'h5A);

    // R4 interval mode wrap, divide by 1
    wr_reg(1, 8'hFE);
    wr_reg(0, 8'h80);
    wait_n(1);
    chk("R4 before wrap irq", tmr_irq, 0);
    wait_n(1);
    chk("R4 irq pulse", tmr_irq, 1);
    chk("R4 flag set", ovf_flag, 1);
    chk("R4 no rst in irq mode", tmr_rst, 0);
    chk("R4 count wrapped", count_val, 0);
    wait_n(1);
    chk("R4 irq one cycle", tmr_irq, 0);
    wr_reg(0, 8'hA0);
    chk("R2 flag write one keeps", ovf_flag, 1);
    wr_reg(0, 8'h00);
    chk("R2 flag write zero clears", ovf_flag, 0);

    // R4 timer disabled: counter holds, no pulses
    wr_reg(1, 8'hFF);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      wait_n(1);
      if (tmr_rst || tmr_irq) pulses++;
    end
    chk("R4 disabled holds", count_val, 8'hFF);
    chk("R4 disabled no pulse", pulses, 0);

    // R4 reset mode with divide by 4 (R3 code 1)
    wr_reg(1, 8'hFC);
    wr_reg(0, 8'hC1);
    wait_n(15);
    chk("R3 div4 before wrap", count_val, 8'hFF);
    chk("R4 rst not yet", tmr_rst, 0);
    wait_n(1);
    chk("R4 rst pulse", tmr_rst, 1);
    chk("R4 no irq in rst mode", tmr_irq, 0);
    chk("R4 flag rst mode", ovf_flag, 1);
    wr_reg(0, 8'h00);

    // R3 random prescale/step trials
    for (int t = 0; t < 6; t++) begin
      int cks, n, p, k;
      cks = $urandom % 5;
      n = div_of(cks);
      p = $urandom % 128;
      k = 1 + ($urandom % 8);
      wr_reg(1, 8'(p));
      wr_reg(0, 8'(8'h80 | cks));
      wait_n(n * k - 1);
      chk("R3 step before", count_val, 8'(p + k - 1));
      wait_n(1);
      chk("R3 step at", count_val, 8'(p + k));
      wr_reg(0, 8'h00);
    end

    // R5/R6/R7 standby with nmi wake, stby_bit held
    stby_bit = 1;
    wr_reg(1, 8'hF8);
    wr_reg(0, 8'h00);
    stby_req = 1; wait_n(1); stby_req = 0;
    chk("R5 clock gated", clk_en, 0);
    wait_n(10);
    chk("R5 count held", count_val, 8'hF8);
    nmi_edge = 1; wait_n(1); nmi_edge = 0;
    wait_n(wrap_cycles(8'hF8, 0) - 1);
    chk("R6 gated before wrap", clk_en, 0);
    chk("R6 count before wrap", count_val, 8'hFF);
    wait_n(1);
    chk("R6 clock back", clk_en, 1);
    chk("R6 count zero", count_val, 0);
    chk("R6 flag clear", ovf_flag, 0);
    wait_n(1);
    chk("R6 continues", count_val, 1);
    wait_n(127);
    chk("R7 at half value", count_val, 8'h80);
    chk("R7 clock still on", clk_en, 1);
    wait_n(1);
    chk("R7 relocked", clk_en, 0);
    nmi_edge = 1; irq_evt = 1; frq_wr = 1; wait_n(1);
    nmi_edge = 0; irq_evt = 0; frq_wr = 0;
    wait_n(20);
    chk("R7 wake ignored", clk_en, 0);
    chk("R7 count frozen", count_val, 8'h80);
    do_reset();
    chk("R7 reset releases", clk_en, 1);

    // R5/R8 irq wake, then clear stby_bit
    stby_bit = 1;
    wr_reg(1, 8'hFE);
    wr_reg(0, 8'h01);
    stby_req = 1; wait_n(1); stby_req = 0;
    irq_evt = 1; wait_n(1); irq_evt = 0;
    wait_n(wrap_cycles(8'hFE, 1));
    chk("R5 irq wake clock", clk_en, 1);
    chk("R6 irq wake zero", count_val, 0);
    wait_n(8);
    chk("R6 counting after wake", count_val, 2);
    stby_bit = 0;
    wait_n(21);
    chk("R8 count stopped", count_val, 2);
    chk("R8 clock stays", clk_en, 1);
    chk("R8 flag clear", ovf_flag, 0);

    // R9/R10 directed, divide by 4096, ratio 1:1
    ratio_unity = 1;
    wr_reg(1, 8'hFF);
    wr_reg(0, 8'h07);
    frq_wr = 1; wait_n(1); frq_wr = 0;
    chk("R9 clock gated", clk_en, 0);
    wait_n(wrap_cycles(8'hFF, 7) - 1);
    chk("R9 gated before wrap", clk_en, 0);
    wait_n(1);
    chk("R9 clock restored", clk_en, 1);
    chk("R9 flag clear", ovf_flag, 0);
    wait_n(10);
    chk("R10 halt at zero", count_val, 0);

    // R9/R10 random frequency changes
    for (int t = 0; t < 6; t++) begin
      int cks, n, p, r, tw;
      cks = $urandom % 3;
      n = div_of(cks);
      p = 8'hC0 + ($urandom % 64);
      r = $urandom % 2;
      ratio_unity = r[0];
      tw = wrap_cycles(p, cks);
      wr_reg(1, 8'(p));
      wr_reg(0, 8'(cks));
      frq_wr = 1; wait_n(1); frq_wr = 0;
      wait_n(tw - 1);
      chk("R9 rand gated", clk_en, 0);
      wait_n(1);
      chk("R9 rand restored", clk_en, 1);
      chk("R9 rand zero", count_val, 0);
      chk("R9 rand flag", ovf_flag, 0);
      wait_n(n + 4);
      chk("R10 rand stop value", count_val, (r == 1) ? 0 : 1);
      chk("R10 rand clock", clk_en, 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule